// File: doc/BRIEF.md
# Configuration Clock Burst Generator

This peripheral produces a counted burst of configuration clock pulses on a single output pin. Software writes a pulse count into a launch register. The block then toggles its clock output at a fixed fraction of the system clock until that many pulses have gone out. When the burst ends it raises a sticky completion flag.

Software polls the completion flag to pace the steps of a device configuration sequence. A typical step requests a few hundred or a couple of thousand idle clocks and waits for them to finish. The flag stays set until software writes a one to it, or until a new burst is launched.

Top module: `dclk_burst_gen`

## Requirements
- R1: After a synchronous reset the clock output is low, the completion flag is clear, and the status register reads 0.
- R2: A write of N (N > 0) to the count register at byte offset 0x8 produces exactly N pulses. The completion flag is set 2·DIV·N system cycles after the write edge.
- R3: Each pulse is high for DIV system cycles and then low for DIV system cycles, and the output stays low whenever no burst is active.
- R4: A read of the status register at offset 0xC returns the completion flag in bit 0 and zero in all other bits. A read of any other offset returns 0.
- R5: A write to the status register with bit 0 set clears the completion flag.
- R6: A write to the status register with bit 0 clear leaves the completion flag unchanged.
- R7: A write of 0 to the count register sets the completion flag at the write edge and produces no pulse.
- R8: A count write during an active burst, or while the flag is set, restarts the burst with the new count and clears the flag. After it, exactly the new count of pulses follow.
- R9: The count is 32 bits wide, and bursts of 256 and 2047 pulses complete correctly.
- R10: Read data is registered: the value for the address presented in one cycle appears after the next clock edge.
- R11: Writes to offsets other than 0x8 and 0xC have no effect on the output or the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Registered read data |
| dclk_o | output | 1 | Configuration clock output |

## Verification
The bench builds the block with DIV = 2, which sets a four-cycle pulse period. With that period, 2047-pulse bursts fit in a short run, and the check of exact high and low widths at a divide above one stays meaningful. The 32-bit count and the 0x8/0xC offsets keep their defaults. The long and short bursts, the zero count and the reload case are therefore all exercised against the real address map.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

  // Decoded register command for one cycle
  typedef struct packed {
    logic launch;  // count register written
    logic clear;   // status written with bit 0 set
  } dclk_cmd_t;

endpackage

// File: rtl/dclk_regif.sv
module dclk_regif
  import dclk_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int CNT_OFFS  = 8,
  parameter int STAT_OFFS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              done,
  output dclk_cmd_t         cmd,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_OFFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFFS);

  always_comb begin
    cmd.launch = wr_en && (wr_addr == CNT_A);
    cmd.clear  = wr_en && (wr_addr == STAT_A) && wr_data[0];
    count      = wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_addr == STAT_A) begin
      rd_data <= {{(DATA_W-1){1'b0}}, done};
    end else begin
      rd_data <= '0;
    end
  end

  AST_RD_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == STAT_A) |=> (rd_data[0] == $past(done))); // R10

endmodule

// File: rtl/dclk_pulse_engine.sv
module dclk_pulse_engine #(
  parameter int CNT_W = 32,
  parameter int DIV   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [CNT_W-1:0] count,
  output logic             dclk_q,
  output logic             busy,
  output logic             finish
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] divcnt;
  logic [CNT_W-1:0] remain;
  logic             last_tick;

  assign last_tick = busy && (divcnt == '0) && !dclk_q && (remain == CNT_W'(1));
  assign finish    = launch ? (count == '0) : last_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      dclk_q <= 1'b0;
      divcnt <= '0;
      remain <= '0;
    end else if (launch) begin
      divcnt <= DIV_LAST;
      remain <= count;
      busy   <= (count != '0);
      dclk_q <= (count != '0);
    end else if (busy) begin
      if (divcnt != '0) begin
        divcnt <= divcnt - 1'b1;
      end else if (dclk_q) begin
        dclk_q <= 1'b0;
        divcnt <= DIV_LAST;
      end else if (remain == CNT_W'(1)) begin
        busy   <= 1'b0;
        remain <= '0;
      end else begin
        remain <= remain - 1'b1;
        dclk_q <= 1'b1;
        divcnt <= DIV_LAST;
      end
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !dclk_q); // R3

  AST_REMAIN_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    (busy && !launch) |=> (remain <= $past(remain))); // R2

  generate
    if (DIV >= 2) begin : g_width
      AST_HIGH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $rose(dclk_q) |=> dclk_q); // R3
    end
  endgenerate

endmodule

// File: rtl/dclk_done_flag.sv
module dclk_done_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic launch,
  input  logic clr,
  output logic done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
    end else if (set) begin
      done <= 1'b1;
    end else if (launch || clr) begin
      done <= 1'b0;
    end
  end

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set && !launch && !clr) |=> $stable(done)); // R6

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !done); // R5

endmodule

// File: rtl/dclk_burst_gen.sv
module dclk_burst_gen
  import dclk_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int DIV       = 2,
  parameter int CNT_OFFS  = 8,
  parameter int STAT_OFFS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              dclk_o
);

  dclk_cmd_t        cmd;
  logic [CNT_W-1:0] count;
  logic             done;
  logic             busy;
  logic             finish;

  dclk_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CNT_OFFS(CNT_OFFS), .STAT_OFFS(STAT_OFFS)
  ) regif_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .done(done),
    .cmd(cmd), .count(count), .rd_data(rd_data)
  );

  dclk_pulse_engine #(.CNT_W(CNT_W), .DIV(DIV)) engine_i (
    .clk(clk), .rst(rst), .launch(cmd.launch), .count(count),
    .dclk_q(dclk_o), .busy(busy), .finish(finish)
  );

  dclk_done_flag flag_i (
    .clk(clk), .rst(rst), .set(finish), .launch(cmd.launch),
    .clr(cmd.clear), .done(done)
  );

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (cmd.launch && count == '0) |=> (done && !dclk_o)); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R2

  AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cmd.launch && count != '0) |=> (!done && dclk_o)); // R8

endmodule

// File: tb/dclk_burst_gen_tb_top.sv
module dclk_burst_gen_tb_top;

  localparam int DIV  = 2;
  localparam int NVEC = 7;
  localparam logic [31:0] VEC_N [NVEC] = '{32'd1, 32'd2, 32'd5, 32'd0, 32'd256, 32'd2047, 32'd3};
  localparam int          VEC_P [NVEC] = '{1, 2, 5, 0, 256, 2047, 3};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = 8'h0C;
  logic [31:0] rd_data;
  logic        dclk_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_total = 0;

  always #10 clk = ~clk;

  dclk_burst_gen #(.DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .dclk_o(dclk_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // Counts pulses and cycles until the status flag reads 1; flags bad widths
  task automatic measure(output int pulses, output int cycles, output int badw);
    logic prev = 1'b0;
    int   run  = 0;
    pulses = 0; cycles = 0; badw = 0;
    while (!rd_data[0] && cycles < 20000) begin
      if (dclk_o && !prev) pulses++;
      if (dclk_o) run++;
      if (!dclk_o && prev) begin
        if (run != DIV) badw++;
        run = 0;
      end
      prev = dclk_o;
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int p, c, w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dclk_o == 1'b0, "R1 dclk after reset", int'(dclk_o), 0);
    chk(rd_data == 32'd0, "R1 status after reset", int'(rd_data), 0);

    // Table walk: R2 R3 R7 R9
    for (int i = 0; i < NVEC; i++) begin
      wr(8'h08, VEC_N[i]);
      measure(p, c, w);
      chk(p == VEC_P[i], "R2 pulse count", p, VEC_P[i]);
      chk(c == 2 * DIV * VEC_P[i] + 1, "R2 done latency", c, 2 * DIV * VEC_P[i] + 1);
      chk(w == 0, "R3 pulse width", w, 0);
      if (VEC_P[i] >= 256) chk(p == VEC_P[i], "R9 long burst", p, VEC_P[i]);
      if (VEC_P[i] == 0) chk(p == 0 && c == 1, "R7 zero count", p, 0);
      chk(dclk_o == 1'b0, "R3 idle low", int'(dclk_o), 0);
      chk(rd_data == 32'd1, "R4 status value", int'(rd_data), 1);
      if (i == 2) begin
        wr(8'h0C, 32'h0000_0002);
        @(negedge clk);
        chk(rd_data == 32'd1, "R6 write zero bit0", int'(rd_data), 1);
        rd_addr = 8'h00;
        @(negedge clk);
        chk(rd_data == 32'd0, "R4 other offset reads 0", int'(rd_data), 0);
        rd_addr = 8'h0C;
        @(negedge clk);
        chk(rd_data == 32'd1, "R10 read latency", int'(rd_data), 1);
      end
      wr(8'h0C, 32'h1);
      @(negedge clk);
      chk(rd_data == 32'd0, "R5 clear", int'(rd_data), 0);
    end

    // R11: write to an unmapped offset
    wr(8'h04, 32'd5);
    begin
      int rises = 0;
      logic pv = 1'b0;
      repeat (30) begin
        @(negedge clk);
        if (dclk_o && !pv) rises++;
        pv = dclk_o;
      end
      chk(rises == 0 && rd_data == 32'd0, "R11 unmapped write", rises, 0);
    end

    // R8: reload mid-burst
    wr(8'h08, 32'd10);
    repeat (7) @(negedge clk);
    wr(8'h08, 32'd3);
    measure(p, c, w);
    chk(p == 3, "R8 reload pulses", p, 3);
    chk(c == 2 * DIV * 3 + 1, "R8 reload latency", c, 2 * DIV * 3 + 1);

    // R8: launch while flag set clears it
    wr(8'h08, 32'd4);
    @(negedge clk);
    chk(rd_data == 32'd0, "R8 launch clears done", int'(rd_data), 0);
    measure(p, c, w);
    chk(p == 4, "R8 pulses after relaunch", p, 4);

    // R1: reset in mid-burst
    wr(8'h08, 32'd20);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dclk_o == 1'b0 && rd_data == 32'd0, "R1 reset mid-burst", int'(dclk_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule